// File: doc/BRIEF.md
# Reloadable 16x Baud Rate Divider

This block turns a fast reference clock into a one-cycle enable that fires sixteen times per serial bit period. The division ratio is a 16-bit value that software loads one byte at a time into a low-byte holding latch and a high-byte holding latch. For a wanted bit rate, the value to load is the reference frequency divided by sixteen times that bit rate. Loadable values run from 1 to 65535, and a value of 0 parks the divider.

Each latch has its own write strobe and its own byte of data. Whenever either latch is written, the internal down counter restarts at once from the newly assembled value. Without that restart, the counter would run out whatever stale count it held, which can take up to 65535 cycles. The enable output drives a transmitter or receiver bit timer. The assembled divisor is also brought out so that it can be read back.

Top module: `baud_div16`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, and in the first cycle after it is released, divisor reads 0 and tick_16x is low.
- R2: A clock edge that samples lo_we high loads lo_data into divisor[7:0] and leaves divisor[15:8] unchanged, unless hi_we is also high at that edge.
- R3: A clock edge that samples hi_we high loads hi_data into divisor[15:8] and leaves divisor[7:0] unchanged, unless lo_we is also high at that edge.
- R4: On any edge where neither strobe is high, divisor keeps its value.
- R5: The edge that captures a write reloads the counter from the new divisor D. When D is 1 or more, tick_16x is low for the next D-1 cycles and high in the D-th cycle after that edge. This holds even when the write lands in the middle of a count.
- R6: With a steady divisor D of 2 or more, tick_16x is high for exactly one cycle out of every D cycles.
- R7: With a steady divisor of 1, tick_16x is high in every cycle.
- R8: With a divisor of 0, tick_16x stays low.
- R9: When both strobes are high at the same edge, the whole 16-bit divisor changes at that edge, and the counter reloads from the combined value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_we | input | 1 | Write strobe for the low divisor byte |
| lo_data | input | 8 | Data for the low divisor byte |
| hi_we | input | 1 | Write strobe for the high divisor byte |
| hi_data | input | 8 | Data for the high divisor byte |
| tick_16x | output | 1 | One-cycle enable at 16 times the bit rate |
| divisor | output | 16 | Currently latched divisor |

## Verification
A wrong latch shows up on the divisor port in the cycle right after the write. A wrong counter state shows up only at the next pulse, or where a pulse should have been. So the bench compares tick_16x against an independent cycle-level model in every cycle, and a bad count or a missed reload is reported within one divisor period. Random write traffic with small divisors puts writes at every phase of the count, including the pulse cycle itself. Directed cases cover divisors 0 and 1, writes to both bytes at once, and a reset in the middle of a run.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_DIV_W  = 2 * DEF_BYTE_W;

   // What the counter does on the next edge
   typedef enum logic [1:0] {
      CNT_HOLD   = 2'd0,
      CNT_LOAD   = 2'd1,
      CNT_DEC    = 2'd2,
      CNT_REWIND = 2'd3
   } cnt_act_e;

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
   parameter int unsigned BYTE_W = baud_div_pkg::DEF_BYTE_W,
   parameter int unsigned NLANE  = 2,
   localparam int unsigned DW    = BYTE_W * NLANE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLANE-1:0]  lane_we,
   input  logic [BYTE_W-1:0] lane_data [NLANE],
   output logic [DW-1:0]     div_q,
   output logic [DW-1:0]     div_d,
   output logic              wr_any
);

   logic [BYTE_W-1:0] lane_q [NLANE];
   logic [BYTE_W-1:0] lane_n [NLANE];

   generate
      if (BYTE_W < 1) begin : g_bad_byte
         $error("baud_div_latch: BYTE_W must be at least 1");
      end
      if (NLANE < 1) begin : g_bad_lane
         $error("baud_div_latch: NLANE must be at least 1");
      end

      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         // next value of this byte: new data when strobed, else hold
         always_comb begin
            lane_n[l] = lane_we[l] ? lane_data[l] : lane_q[l];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q[l] <= '0;
            end else begin
               lane_q[l] <= lane_n[l];
            end
         end

         assign div_q[l*BYTE_W +: BYTE_W] = lane_q[l];
         assign div_d[l*BYTE_W +: BYTE_W] = lane_n[l];
      end
   endgenerate

   assign wr_any = |lane_we;

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
   import baud_div_pkg::*;
#(
   parameter int unsigned CNT_W = DEF_DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] div_q,
   output logic             tick
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_n;
   cnt_act_e         act;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("baud_div_counter: CNT_W must be at least 2");
      end
   endgenerate

   // A write wins over everything else. Otherwise count down to 1, rewind
   // from the latched divisor, and stay parked at 0 when the divisor is 0.
   always_comb begin
      if (reload) begin
         act = CNT_LOAD;
      end else if (cnt_q > ONE) begin
         act = CNT_DEC;
      end else if (div_q != ZERO) begin
         act = CNT_REWIND;
      end else begin
         act = CNT_HOLD;
      end
   end

   always_comb begin
      unique case (act)
         CNT_LOAD:   cnt_n = reload_val;
         CNT_DEC:    cnt_n = cnt_q - ONE;
         CNT_REWIND: cnt_n = div_q;
         default:    cnt_n = ZERO;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
      end else begin
         cnt_q <= cnt_n;
      end
   end

   assign tick = (cnt_q == ONE);

endmodule

// File: rtl/baud_div16.sv
module baud_div16
   import baud_div_pkg::*;
#(
   parameter int unsigned BYTE_W = DEF_BYTE_W,
   parameter int unsigned DIV_W  = DEF_DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic [BYTE_W-1:0] lo_data,
   input  logic              hi_we,
   input  logic [BYTE_W-1:0] hi_data,
   output logic              tick_16x,
   output logic [DIV_W-1:0]  divisor
);

   localparam int unsigned NLANE = 2;

   generate
      if (DIV_W != NLANE * BYTE_W) begin : g_bad_width
         $error("baud_div16: DIV_W must equal two bytes");
      end
   endgenerate

   logic [NLANE-1:0]  lane_we;
   logic [BYTE_W-1:0] lane_data [NLANE];
   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  div_d;
   logic              wr_any;

   assign lane_we      = {hi_we, lo_we};
   assign lane_data[0] = lo_data;
   assign lane_data[1] = hi_data;

   baud_div_latch #(
      .BYTE_W (BYTE_W),
      .NLANE  (NLANE)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_we   (lane_we),
      .lane_data (lane_data),
      .div_q     (div_q),
      .div_d     (div_d),
      .wr_any    (wr_any)
   );

   baud_div_counter #(
      .CNT_W (DIV_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload     (wr_any),
      .reload_val (div_d),
      .div_q      (div_q),
      .tick       (tick_16x)
   );

   assign divisor = div_q;

endmodule

// File: rtl/baud_div16_chk.sv
module baud_div16_chk #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned DIV_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lo_we,
   input logic [BYTE_W-1:0] lo_data,
   input logic              hi_we,
   input logic [BYTE_W-1:0] hi_data,
   input logic              tick_16x,
   input logic [DIV_W-1:0]  divisor
);

   // cycles since the last pulse, valid only when no write came in between
   logic [DIV_W-1:0] gap;
   logic             have_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap      <= '0;
         have_ref <= 1'b0;
      end else begin
         if (tick_16x) begin
            gap <= '0;
         end else if (gap != '1) begin
            gap <= gap + 1'b1;
         end
         if (lo_we || hi_we) begin
            have_ref <= 1'b0;
         end else if (tick_16x) begin
            have_ref <= 1'b1;
         end
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (divisor == '0 && !tick_16x));

   p_lo_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && !hi_we) |=> (divisor[BYTE_W-1:0] == $past(lo_data)
                             && $stable(divisor[DIV_W-1:BYTE_W])));

   p_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we && !lo_we) |=> (divisor[DIV_W-1:BYTE_W] == $past(hi_data)
                             && $stable(divisor[BYTE_W-1:0])));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_we && !hi_we) |=> $stable(divisor));

   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we || hi_we) |=> (tick_16x == (divisor == DIV_W'(1))));

   p_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_16x && have_ref) |-> (gap == divisor - DIV_W'(1)));

   p_unit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == DIV_W'(1) && !lo_we && !hi_we) |=> tick_16x);

   p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0 && !lo_we && !hi_we) |=> !tick_16x);

   p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && hi_we) |=> (divisor == {$past(hi_data), $past(lo_data)}));

endmodule

bind baud_div16 baud_div16_chk #(
   .BYTE_W (BYTE_W),
   .DIV_W  (DIV_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lo_we    (lo_we),
   .lo_data  (lo_data),
   .hi_we    (hi_we),
   .hi_data  (hi_data),
   .tick_16x (tick_16x),
   .divisor  (divisor)
);

// File: tb/baud_div16_tb.sv
`timescale 1ns/1ps
module baud_div16_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lo_we = 1'b0;
   logic [7:0] lo_data = '0;
   logic       hi_we = 1'b0;
   logic [7:0] hi_data = '0;
   logic       tick_16x;
   logic [15:0] divisor;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   logic [15:0] m_div = '0;
   logic [15:0] m_cnt = '0;

   always #5 clk = ~clk;

   baud_div16 u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo_we    (lo_we),
      .lo_data  (lo_data),
      .hi_we    (hi_we),
      .hi_data  (hi_data),
      .tick_16x (tick_16x),
      .divisor  (divisor)
   );

   function automatic logic [15:0] merged(input logic lwe, input logic [7:0] ld,
                                          input logic hwe, input logic [7:0] hd);
      merged = {hwe ? hd : m_div[15:8], lwe ? ld : m_div[7:0]};
   endfunction

   // The model counts cycles to the next pulse from the requirements: a pulse
   // lands D cycles after a write edge and then every D cycles.
   function automatic logic [15:0] next_cnt(input logic wr, input logic [15:0] nd);
      if (wr)            next_cnt = nd;
      else if (m_cnt > 1) next_cnt = m_cnt - 1;
      else               next_cnt = m_div;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Inputs are driven just after a falling edge, the model advances at the
   // rising edge, and the outputs are sampled at the following falling edge.
   task automatic step(input logic lwe, input logic [7:0] ld,
                       input logic hwe, input logic [7:0] hd, input string tag);
      logic [15:0] nd;
      lo_we = lwe; lo_data = ld; hi_we = hwe; hi_data = hd;
      nd = merged(lwe, ld, hwe, hd);
      @(posedge clk);
      #1;
      m_cnt = next_cnt(lwe | hwe, nd);
      m_div = nd;
      @(negedge clk);
      lo_we = 1'b0; hi_we = 1'b0;
      check(tag, "divisor", 32'(divisor), 32'(m_div));
      check(tag, "tick", 32'(tick_16x), 32'(m_cnt == 16'd1));
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 8'h00, tag);
   endtask

   // Counts cycles from the write edge to the first pulse.
   task automatic first_pulse(input logic [15:0] d, input string tag);
      int n;
      n = 0;
      step(1'b1, d[7:0], 1'b1, d[15:8], tag);
      n = 1;
      while (!tick_16x && n < 400) begin
         idle(1, tag);
         n++;
      end
      check(tag, "cycles to first pulse", 32'(n), 32'(d));
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      m_div = '0; m_cnt = '0;
      #2;
      check(tag, "divisor in reset", 32'(divisor), 32'h0);
      check(tag, "tick in reset", 32'(tick_16x), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(1, tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1", "divisor in reset", 32'(divisor), 32'h0);
      check("R1", "tick in reset", 32'(tick_16x), 32'h0);
      rst_n = 1'b1;
      idle(3, "R1 R8");

      // low byte only, then high byte only
      step(1'b1, 8'h05, 1'b0, 8'hAA, "R2");
      idle(12, "R6");
      step(1'b0, 8'h33, 1'b1, 8'h00, "R3");
      idle(12, "R4 R6");

      // divisor of one pulses every cycle, zero stops
      first_pulse(16'd1, "R7");
      idle(6, "R7");
      step(1'b1, 8'h00, 1'b1, 8'h00, "R8");
      idle(20, "R8");

      // first pulse after load is exactly D cycles away
      first_pulse(16'd9, "R5");
      first_pulse(16'd2, "R5");
      first_pulse(16'd300, "R5 R9");
      idle(4, "R6");

      // write in the middle of a long count restarts it
      step(1'b1, 8'h20, 1'b1, 8'h01, "R9");
      idle(100, "R4");
      first_pulse(16'd4, "R5");
      idle(10, "R6");

      // write landing on the pulse cycle
      step(1'b1, 8'h03, 1'b1, 8'h00, "R5");
      idle(2, "R5");
      step(1'b1, 8'h06, 1'b0, 8'h00, "R5");
      idle(8, "R6");

      // random traffic with small divisors
      for (int i = 0; i < 6000; i++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[4:0] == 5'd0) begin
            step(r[5], 8'(r[15:8] % 12), r[6], 8'h00, "R5 R2 R3");
         end else begin
            step(1'b0, 8'h00, 1'b0, 8'h00, "R6 R4");
         end
      end

      // high byte large then cleared again
      step(1'b0, 8'h00, 1'b1, 8'h02, "R3");
      idle(5, "R4");
      step(1'b0, 8'h00, 1'b1, 8'h00, "R3");
      idle(30, "R6");

      do_reset("R1");
      idle(10, "R1 R8");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule